// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces memory refresh. An 8-bit interval counter advances on enable pulses from an external prescaler. It advances only while a clock-select field is nonzero. The counter is compared with an 8-bit compare constant. When the two are equal, the counter returns to zero and a compare-match flag is raised. If refresh is enabled and the controller is in auto-refresh mode, a one-cycle refresh request goes to the memory controller. A 10-bit event counter tallies the requests. When it passes a selectable limit, it wraps and raises an overflow flag.

Software reaches four registers over a 16-bit register bus. No write takes effect unless it is a full-word access that carries a key in its upper bits. Power-on reset clears everything. Manual reset clears only the status flags and blocks bus writes. Timing continues during manual reset, so refresh requests are still counted. Standby freezes all state.

Top module: `rfsh_interval_timer`

## Requirements
- R1: Register addresses are 0 for control/status, 1 for the interval counter, 2 for the compare constant and 3 for the event counter. On a prescaler pulse with the clock-select field (control bits [2:0]) nonzero, the interval counter clears if it equals the compare constant and otherwise increments. With a select of 0 the counter holds.
- R2: A compare match raises refresh_req for exactly one cycle, in the cycle after the match. This happens only if refresh_en and auto_mode are both 1.
- R3: The compare-match flag sits at control bit 7 and the overflow flag at bit 6. Writing 0 to a flag clears it and writing 1 leaves it unchanged. A hardware set that falls in the same cycle as a software clear wins.
- R4: A compare constant write needs a word access with upper byte 8'hA5, and the low byte becomes the value. The upper byte reads as zero. Control and interval counter writes use the same key.
- R5: The event counter increments once per refresh request. An increment made while it equals its limit clears it and sets the overflow flag. The limit is 1023 when the limit-select bit (control bit 3) is 0 and 511 when it is 1.
- R6: An event counter write needs a word access whose top six bits are 6'b101001. The low 10 bits become the count.
- R7: A byte access, or a word access with a wrong key, changes no register.
- R8: Power-on reset (por_n low) clears every register, both flags and refresh_req.
- R9: While man_rst is 1, the following hold:
  - the flags are held clear and bus writes are ignored;
  - the compare constant, clock select and limit select keep their values;
  - the interval and event counters keep running.
- R10: While standby is 1, all registers hold their values, no refresh request is raised, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| man_rst | input | 1 | Manual reset, active high |
| standby | input | 1 | Standby, freezes all state |
| presc_tick | input | 1 | Count enable pulse from the prescaler |
| refresh_en | input | 1 | Refresh enable from the memory controller setup |
| auto_mode | input | 1 | 1 selects auto refresh |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 marks a full 16-bit access |
| bus_wdata | input | 16 | Write data including key |
| bus_rdata | output | 16 | Read data of the addressed register |
| refresh_req | output | 1 | One-cycle refresh request |

## Verification
Two pairs of events can land on the same clock edge:
- a compare match setting the compare-match flag, and a software write of 0 to that flag;
- a wrap of the event counter, and a write to that counter.

The bench provokes the first pair by bringing the interval counter up to the compare constant. It then drives the prescaler pulse and the keyed flag-clearing write on the same edge. Reading the control register afterwards must show the flag still set. Both event-counter boundaries are exercised by preloading values just below each limit.

// File: rtl/rfsh_timer_pkg.sv
package rfsh_timer_pkg;
  localparam int BUS_W  = 16;
  localparam int CNT_W  = 8;
  localparam int RFC_W  = 10;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 2;
  localparam int BKEY_W = BUS_W - CNT_W;
  localparam int RKEY_W = BUS_W - RFC_W;
  localparam logic [BKEY_W-1:0] KEY_BYTE = 8'hA5;
  localparam logic [RKEY_W-1:0] KEY_RFC  = 6'b101001;

  typedef enum logic [ADDR_W-1:0] {
    REG_CSR = 2'd0,
    REG_CNT = 2'd1,
    REG_COR = 2'd2,
    REG_RFC = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             wrCsr;
    logic             wrCnt;
    logic             wrCor;
    logic             wrRfc;
    logic [RFC_W-1:0] data;
  } wrStrobes_t;
endpackage

// File: rtl/rfsh_timer_ctrl.sv
module rfsh_timer_ctrl
  import rfsh_timer_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRst,
  input  logic              standby,
  input  logic              busWr,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output wrStrobes_t        strb
);
  logic accessOk, byteKeyOk, rfcKeyOk;

  always_comb begin
    accessOk   = busWr && busWord && !standby && !manRst;
    byteKeyOk  = busWdata[BUS_W-1:CNT_W] == KEY_BYTE;
    rfcKeyOk   = busWdata[BUS_W-1:RFC_W] == KEY_RFC;
    strb       = '0;
    strb.data  = busWdata[RFC_W-1:0];
    strb.wrCsr = accessOk && byteKeyOk && (busAddr == REG_CSR);
    strb.wrCnt = accessOk && byteKeyOk && (busAddr == REG_CNT);
    strb.wrCor = accessOk && byteKeyOk && (busAddr == REG_COR);
    strb.wrRfc = accessOk && rfcKeyOk  && (busAddr == REG_RFC);
  end

  // a byte access never produces a write strobe
  assert_byte_ignored_R7: assert property (@(posedge clk) disable iff (!porRstN)
    (busWr && !busWord) |-> !(strb.wrCsr || strb.wrCnt || strb.wrCor || strb.wrRfc));

  // at most one register is written per access
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({strb.wrCsr, strb.wrCnt, strb.wrCor, strb.wrRfc}));
endmodule

// File: rtl/rfsh_timer_datapath.sv
module rfsh_timer_datapath
  import rfsh_timer_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRst,
  input  logic              standby,
  input  logic              prescTick,
  input  logic              refreshEn,
  input  logic              autoMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  wrStrobes_t        strb,
  output logic [BUS_W-1:0]  busRdata,
  output logic              refreshReq
);
  localparam logic [RFC_W-1:0] LIMIT_FULL = '1;
  localparam logic [RFC_W-1:0] LIMIT_HALF = {1'b0, {(RFC_W-1){1'b1}}};

  logic [CNT_W-1:0] intCnt, cmpConst;
  logic [RFC_W-1:0] evtCnt, evtLimit;
  logic [SEL_W-1:0] clkSel;
  logic             limitSel, cmfFlag, ovfFlag;
  logic             cntAdv, match, evtStep, evtWrap;

  always_comb begin
    cntAdv   = prescTick && (clkSel != '0) && !standby;
    match    = cntAdv && (intCnt == cmpConst);
    evtLimit = limitSel ? LIMIT_HALF : LIMIT_FULL;
    evtStep  = refreshReq && !standby && !strb.wrRfc;
    evtWrap  = evtStep && (evtCnt == evtLimit);
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      intCnt     <= '0;
      cmpConst   <= '0;
      evtCnt     <= '0;
      clkSel     <= '0;
      limitSel   <= 1'b0;
      cmfFlag    <= 1'b0;
      ovfFlag    <= 1'b0;
      refreshReq <= 1'b0;
    end else begin
      refreshReq <= match && refreshEn && autoMode;

      if (strb.wrCnt)      intCnt <= strb.data[CNT_W-1:0];
      else if (match)      intCnt <= '0;
      else if (cntAdv)     intCnt <= intCnt + 1'b1;

      if (strb.wrCor)      cmpConst <= strb.data[CNT_W-1:0];

      if (strb.wrRfc)      evtCnt <= strb.data;
      else if (evtWrap)    evtCnt <= '0;
      else if (evtStep)    evtCnt <= evtCnt + 1'b1;

      if (strb.wrCsr) begin
        clkSel   <= strb.data[SEL_W-1:0];
        limitSel <= strb.data[3];
      end

      if (manRst)                          cmfFlag <= 1'b0;
      else if (match)                      cmfFlag <= 1'b1;
      else if (strb.wrCsr && !strb.data[7]) cmfFlag <= 1'b0;

      if (manRst)                          ovfFlag <= 1'b0;
      else if (evtWrap)                    ovfFlag <= 1'b1;
      else if (strb.wrCsr && !strb.data[6]) ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    case (busAddr)
      REG_CSR: busRdata = {{(BUS_W-8){1'b0}}, cmfFlag, ovfFlag, 2'b00, limitSel, clkSel};
      REG_CNT: busRdata = {{(BUS_W-CNT_W){1'b0}}, intCnt};
      REG_COR: busRdata = {{(BUS_W-CNT_W){1'b0}}, cmpConst};
      default: busRdata = {{(BUS_W-RFC_W){1'b0}}, evtCnt};
    endcase
  end

  assert_match_clears_R1: assert property (@(posedge clk) disable iff (!porRstN)
    (match && !strb.wrCnt && !manRst) |=> (intCnt == '0) && cmfFlag);

  assert_sel_zero_holds_R1: assert property (@(posedge clk) disable iff (!porRstN)
    (clkSel == '0 && !strb.wrCnt) |=> $stable(intCnt));

  assert_req_gated_R2: assert property (@(posedge clk) disable iff (!porRstN)
    !(match && refreshEn && autoMode) |=> !refreshReq);

  assert_req_single_R2: assert property (@(posedge clk) disable iff (!porRstN)
    refreshReq |=> !refreshReq);

  assert_flag_set_wins_R3: assert property (@(posedge clk) disable iff (!porRstN)
    (match && strb.wrCsr && !manRst) |=> cmfFlag);

  assert_evt_wrap_R5: assert property (@(posedge clk) disable iff (!porRstN)
    (evtWrap && !manRst) |=> (evtCnt == '0) && ovfFlag);

  assert_standby_hold_R10: assert property (@(posedge clk) disable iff (!porRstN)
    standby |=> $stable(cmpConst) && $stable(evtCnt) && $stable(intCnt) && !refreshReq);

  assert_manrst_flags_R9: assert property (@(posedge clk) disable iff (!porRstN)
    manRst |=> !cmfFlag && !ovfFlag && $stable(cmpConst));
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import rfsh_timer_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              man_rst,
  input  logic              standby,
  input  logic              presc_tick,
  input  logic              refresh_en,
  input  logic              auto_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              refresh_req
);
  wrStrobes_t strb;

  rfsh_timer_ctrl ctrl_i (
    .clk      (clk),
    .porRstN  (por_n),
    .manRst   (man_rst),
    .standby  (standby),
    .busWr    (bus_wr),
    .busWord  (bus_word),
    .busAddr  (bus_addr),
    .busWdata (bus_wdata),
    .strb     (strb)
  );

  rfsh_timer_datapath dp_i (
    .clk        (clk),
    .porRstN    (por_n),
    .manRst     (man_rst),
    .standby    (standby),
    .prescTick  (presc_tick),
    .refreshEn  (refresh_en),
    .autoMode   (auto_mode),
    .busAddr    (bus_addr),
    .strb       (strb),
    .busRdata   (bus_rdata),
    .refreshReq (refresh_req)
  );
endmodule

// File: tb/rfsh_interval_timer_tb.sv
`timescale 1ns/1ps
module rfsh_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, man_rst = 1'b0, standby = 1'b0, presc_tick = 1'b0;
  logic        refresh_en = 1'b1, auto_mode = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        refresh_req;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  rfsh_interval_timer dut_i (
    .clk(clk), .por_n(por_n), .man_rst(man_rst), .standby(standby),
    .presc_tick(presc_tick), .refresh_en(refresh_en), .auto_mode(auto_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .refresh_req(refresh_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic checkReg(input string req, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] d;
    readReg(a, d);
    check(req, d, exp);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d, input logic word);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_word = word; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b0;
  endtask

  // one prescaler pulse; returns refresh_req seen in the following cycle
  task automatic tick(output logic reqSeen);
    @(negedge clk);
    presc_tick = 1'b1;
    @(negedge clk);
    presc_tick = 1'b0;
    reqSeen = refresh_req;
  endtask

  task automatic testReset();
    checkReg("R8", 2'd0, 16'h0000);
    checkReg("R8", 2'd1, 16'h0000);
    checkReg("R8", 2'd2, 16'h0000);
    checkReg("R8", 2'd3, 16'h0000);
    check("R8", {15'd0, refresh_req}, 16'd0);
  endtask

  task automatic testKeyedWrites();
    writeReg(2'd2, 16'hA503, 1'b1);
    checkReg("R4 keyed write", 2'd2, 16'h0003);
    writeReg(2'd2, 16'h5A09, 1'b1);
    checkReg("R7 wrong key", 2'd2, 16'h0003);
    writeReg(2'd2, 16'hA509, 1'b0);
    checkReg("R7 byte access", 2'd2, 16'h0003);
    writeReg(2'd1, 16'h3C01, 1'b1);
    checkReg("R7 wrong key cnt", 2'd1, 16'h0000);
  endtask

  task automatic testCompare();
    logic r;
    writeReg(2'd0, 16'hA501, 1'b1);
    for (int i = 0; i < 3; i++) begin
      tick(r);
      check("R2 no early req", {15'd0, r}, 16'd0);
    end
    checkReg("R1 counting", 2'd1, 16'h0003);
    tick(r);
    check("R2 req on match", {15'd0, r}, 16'd1);
    checkReg("R1 cleared on match", 2'd1, 16'h0000);
    checkReg("R3 cmf set", 2'd0, 16'h0081);
    @(negedge clk);
    check("R2 single pulse", {15'd0, refresh_req}, 16'd0);
    checkReg("R5 evt incr", 2'd3, 16'h0001);
    writeReg(2'd0, 16'hA5C0, 1'b1);
    tick(r);
    checkReg("R1 select zero holds", 2'd1, 16'h0000);
  endtask

  task automatic testFlags();
    logic r;
    writeReg(2'd0, 16'hA5C1, 1'b1);
    checkReg("R3 write 1 keeps", 2'd0, 16'h0081);
    writeReg(2'd0, 16'hA541, 1'b1);
    checkReg("R3 write 0 clears", 2'd0, 16'h0001);
    for (int i = 0; i < 3; i++) tick(r);
    @(negedge clk);
    presc_tick = 1'b1; bus_addr = 2'd0; bus_wdata = 16'hA541; bus_word = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    presc_tick = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
    checkReg("R3 set wins over clear", 2'd0, 16'h0081);
  endtask

  task automatic testGate();
    logic r;
    writeReg(2'd2, 16'hA500, 1'b1);
    writeReg(2'd1, 16'hA500, 1'b1);
    refresh_en = 1'b0;
    tick(r);
    check("R2 disabled no req", {15'd0, r}, 16'd0);
    @(negedge clk);
    checkReg("R2 evt unchanged", 2'd3, 16'h0002);
    refresh_en = 1'b1; auto_mode = 1'b0;
    tick(r);
    check("R2 manual mode no req", {15'd0, r}, 16'd0);
    auto_mode = 1'b1;
  endtask

  task automatic testEvtCounter();
    logic r;
    writeReg(2'd3, 16'hA7FE, 1'b1);
    checkReg("R6 keyed write", 2'd3, 16'h03FE);
    writeReg(2'd3, 16'hA3FF, 1'b1);
    checkReg("R6 wrong key", 2'd3, 16'h03FE);
    tick(r); @(negedge clk);
    checkReg("R5 reach 1023", 2'd3, 16'h03FF);
    checkReg("R5 no ovf yet", 2'd0, 16'h0081);
    tick(r); @(negedge clk);
    checkReg("R5 wrap 1023", 2'd3, 16'h0000);
    checkReg("R5 ovf set", 2'd0, 16'h00C1);
    writeReg(2'd0, 16'hA589, 1'b1);
    writeReg(2'd3, 16'hA5FF, 1'b1);
    tick(r); @(negedge clk);
    checkReg("R5 wrap 511", 2'd3, 16'h0000);
    checkReg("R5 ovf half limit", 2'd0, 16'h00C9);
  endtask

  task automatic testManualReset();
    logic r;
    @(negedge clk); man_rst = 1'b1;
    @(negedge clk);
    checkReg("R9 flags cleared", 2'd0, 16'h0009);
    tick(r); @(negedge clk);
    check("R9 req continues", {15'd0, r}, 16'd1);
    checkReg("R9 evt keeps counting", 2'd3, 16'h0001);
    writeReg(2'd2, 16'hA507, 1'b1);
    checkReg("R9 const held", 2'd2, 16'h0000);
    @(negedge clk); man_rst = 1'b0;
  endtask

  task automatic testStandby();
    logic r;
    @(negedge clk); standby = 1'b1;
    tick(r); @(negedge clk);
    check("R10 no req", {15'd0, r}, 16'd0);
    checkReg("R10 evt held", 2'd3, 16'h0001);
    writeReg(2'd2, 16'hA507, 1'b1);
    checkReg("R10 write ignored", 2'd2, 16'h0000);
    @(negedge clk); standby = 1'b0;
  endtask

  task automatic testPor();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    checkReg("R8 por csr", 2'd0, 16'h0000);
    checkReg("R8 por evt", 2'd3, 16'h0000);
    @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    por_n = 1'b1;
    @(negedge clk);
    testReset();
    testKeyedWrites();
    testCompare();
    testFlags();
    testGate();
    testEvtCounter();
    testManualReset();
    testStandby();
    testPor();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule